// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block is a small direct-mapped, tagged table that the instruction fetch stage consults with the current fetch address before the instruction has been decoded. In the same cycle it reports whether that address belongs to a branch it has seen taken before. It also gives the address fetch should use next. That is the stored target when the entry's 2-bit direction counter leans taken, and the sequential address (fetch address plus 4) otherwise.

The execute stage reports each resolved branch through a resolve port. A taken branch that is not in the table is allocated with a weakly-taken counter. A not-taken branch that is absent is never allocated. A branch that is present has its counter trained with saturation, and its target is replaced when a taken outcome goes somewhere else. Two one-cycle error pulses tell the pipeline which kind of error happened: a taken branch that fetch never knew about, or a known branch whose direction or destination was predicted wrongly.

Top module: `btb_redirect`

## Requirements
- R1: After reset is asserted, every entry is invalid. `hit`, `pred_taken`, `misfetch` and `mispredict` are 0, and `next_pc` equals `fetch_pc + 4` for any fetch address.
- R2: The table has 16 entries. The entry is selected by `fetch_pc[5:2]`, and every other bit of the address is stored and compared. `hit` is 1 in the same cycle as `fetch_pc`, exactly when the selected entry is valid and all compared bits match.
- R3: `pred_taken` is 1 when `hit` is 1 and the entry's counter is 2 or 3. In that case `next_pc` is the stored target. Otherwise `next_pc` is `fetch_pc + 4`.
- R4: A resolve with `res_taken`=1 whose address misses writes the entry at its index. The written entry is valid, holds that address and `res_target`, and has counter 2 (weakly taken). It replaces whatever was there, so a later lookup of the replaced address misses.
- R5: A resolve with `res_taken`=0 whose address misses changes no entry.
- R6: A resolve that hits moves the counter up by one on taken and down by one on not-taken, holding at 3 and at 0. The counter encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken.
- R7: A taken resolve that hits stores `res_target` as the new target. A not-taken resolve that hits leaves the target unchanged.
- R8: `misfetch` is 1 for exactly the cycle after a resolve that was taken and missed.
- R9: `mispredict` is 1 for exactly the cycle after a resolve that hit and either disagreed with the counter's direction, or was taken and predicted taken with a target different from the stored one. It is never 1 together with `misfetch`.
- R10: When `res_valid` is 0, no entry changes, and in the following cycle both `misfetch` and `mispredict` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_pc | input | 32 | Address being fetched this cycle |
| res_valid | input | 1 | A branch resolution is presented this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Resolved direction, 1 = taken |
| res_target | input | 32 | Resolved target of the branch |
| hit | output | 1 | Fetch address found in the table |
| pred_taken | output | 1 | Fetch address predicted as a taken branch |
| next_pc | output | 32 | Address to fetch next |
| misfetch | output | 1 | One-cycle pulse: taken branch was missing from the table |
| mispredict | output | 1 | One-cycle pulse: known branch had a wrong direction or target |

## Verification
The hardest case to reach from the ports is a target-only mispredict. It needs an entry that has already been allocated and trained to predict taken, and then a taken resolve to a different destination. The other hard case is an alias that evicts a live entry at the same index. The directed part builds both in order: allocate, saturate, train down to strong not-taken, retrain, redirect the target, then evict with a second address of the same index. The random part draws addresses and targets from deliberately small pools. This makes hits, aliasing and repeated targets frequent, and a bench model scores every cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // 2-bit direction state; the upper bit is the taken prediction
  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_t;

  localparam ctr_t CTR_ALLOC = CTR_WT;

  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_t'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_t'(cur - 2'd1);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/btb_rst_sync.sv
module btb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = PC_W - IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  // fetch read port
  input  logic [IDX_W-1:0] fa_idx,
  output logic             fa_valid,
  output logic [TAG_W-1:0] fa_tag,
  output logic [PC_W-1:0]  fa_tgt,
  output ctr_t             fa_ctr,
  // resolve read port
  input  logic [IDX_W-1:0] rb_idx,
  output logic             rb_valid,
  output logic [TAG_W-1:0] rb_tag,
  output logic [PC_W-1:0]  rb_tgt,
  output ctr_t             rb_ctr,
  // single write port
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_alloc,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_tgt_en,
  input  logic [PC_W-1:0]  wr_tgt,
  input  ctr_t             wr_ctr
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  ctr_t               ctr_q [ENTRIES];

  logic tag_ce;
  logic tgt_ce;
  logic ctr_ce;

  // next-state of the valid vector
  always_comb begin
    valid_d = valid_q;
    if (wr_en && wr_alloc) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // clock enables of the payload arrays
  assign tag_ce = wr_en && wr_alloc;
  assign tgt_ce = wr_en && wr_tgt_en;
  assign ctr_ce = wr_en;

  // payload arrays: contents only matter once valid is set
  always_ff @(posedge clk) begin
    if (tag_ce) tag_q[wr_idx] <= wr_tag;
    if (tgt_ce) tgt_q[wr_idx] <= wr_tgt;
    if (ctr_ce) ctr_q[wr_idx] <= wr_ctr;
  end

  assign fa_valid = valid_q[fa_idx];
  assign fa_tag   = tag_q[fa_idx];
  assign fa_tgt   = tgt_q[fa_idx];
  assign fa_ctr   = ctr_q[fa_idx];

  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_tgt   = tgt_q[rb_idx];
  assign rb_ctr   = ctr_q[rb_idx];

endmodule

// File: rtl/btb_fetch.sv
module btb_fetch
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 28
) (
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic             e_valid,
  input  logic [TAG_W-1:0] e_tag,
  input  logic [PC_W-1:0]  e_tgt,
  input  ctr_t             e_ctr,
  output logic             hit,
  output logic             pred_taken,
  output logic [PC_W-1:0]  next_pc
);

  localparam logic [PC_W-1:0] SEQ_STEP = PC_W'(4);

  logic [PC_W-1:0] seq_pc;

  assign seq_pc     = fetch_pc + SEQ_STEP;
  assign hit        = e_valid && (e_tag == fetch_tag);
  assign pred_taken = hit && e_ctr[1];
  assign next_pc    = pred_taken ? e_tgt : seq_pc;

endmodule

// File: rtl/btb_resolve.sv
module btb_resolve
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int TAG_W = 28
) (
  input  logic             res_valid,
  input  logic [TAG_W-1:0] res_tag,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  input  logic             e_valid,
  input  logic [TAG_W-1:0] e_tag,
  input  logic [PC_W-1:0]  e_tgt,
  input  ctr_t             e_ctr,
  output logic             wr_en,
  output logic             wr_alloc,
  output logic             wr_tgt_en,
  output ctr_t             wr_ctr,
  output logic             misfetch_d,
  output logic             mispredict_d
);

  logic in_table;
  logic guess_taken;
  logic tgt_differs;
  logic dir_wrong;

  always_comb begin
    in_table    = e_valid && (e_tag == res_tag);
    guess_taken = e_ctr[1];
    tgt_differs = (e_tgt != res_target);
    dir_wrong   = (guess_taken != res_taken);

    wr_en     = res_valid && (in_table || res_taken);
    wr_alloc  = !in_table;
    wr_tgt_en = !in_table || (res_taken && tgt_differs);
    wr_ctr    = in_table ? ctr_train(e_ctr, res_taken) : CTR_ALLOC;

    misfetch_d   = res_valid && !in_table && res_taken;
    mispredict_d = res_valid && in_table &&
                   (dir_wrong || (guess_taken && res_taken && tgt_differs));
  end

endmodule

// File: rtl/btb_redirect.sv
module btb_redirect
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFF_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output logic            hit,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc,
  output logic            misfetch,
  output logic            mispredict
);

  localparam int TAG_W  = PC_W - IDX_W;
  localparam int IDX_LO = OFF_W;
  localparam int IDX_HI = OFF_W + IDX_W - 1;

  logic rst_q_n;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag;

  logic             fa_valid, rb_valid;
  logic [TAG_W-1:0] fa_tag, rb_tag;
  logic [PC_W-1:0]  fa_tgt, rb_tgt;
  ctr_t             fa_ctr, rb_ctr;

  logic wr_en, wr_alloc, wr_tgt_en;
  ctr_t wr_ctr;

  logic misfetch_d, mispredict_d;
  logic misfetch_q, mispredict_q;

  btb_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // index from the middle bits, everything else is compared
  assign f_idx = fetch_pc[IDX_HI:IDX_LO];
  assign r_idx = res_pc[IDX_HI:IDX_LO];
  assign f_tag = {fetch_pc[PC_W-1:IDX_HI+1], fetch_pc[OFF_W-1:0]};
  assign r_tag = {res_pc[PC_W-1:IDX_HI+1], res_pc[OFF_W-1:0]};

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .fa_idx    (f_idx),
    .fa_valid  (fa_valid),
    .fa_tag    (fa_tag),
    .fa_tgt    (fa_tgt),
    .fa_ctr    (fa_ctr),
    .rb_idx    (r_idx),
    .rb_valid  (rb_valid),
    .rb_tag    (rb_tag),
    .rb_tgt    (rb_tgt),
    .rb_ctr    (rb_ctr),
    .wr_en     (wr_en),
    .wr_idx    (r_idx),
    .wr_alloc  (wr_alloc),
    .wr_tag    (r_tag),
    .wr_tgt_en (wr_tgt_en),
    .wr_tgt    (res_target),
    .wr_ctr    (wr_ctr)
  );

  btb_fetch #(.PC_W(PC_W), .TAG_W(TAG_W)) u_fetch (
    .fetch_pc   (fetch_pc),
    .fetch_tag  (f_tag),
    .e_valid    (fa_valid),
    .e_tag      (fa_tag),
    .e_tgt      (fa_tgt),
    .e_ctr      (fa_ctr),
    .hit        (hit),
    .pred_taken (pred_taken),
    .next_pc    (next_pc)
  );

  btb_resolve #(.PC_W(PC_W), .TAG_W(TAG_W)) u_resolve (
    .res_valid    (res_valid),
    .res_tag      (r_tag),
    .res_taken    (res_taken),
    .res_target   (res_target),
    .e_valid      (rb_valid),
    .e_tag        (rb_tag),
    .e_tgt        (rb_tgt),
    .e_ctr        (rb_ctr),
    .wr_en        (wr_en),
    .wr_alloc     (wr_alloc),
    .wr_tgt_en    (wr_tgt_en),
    .wr_ctr       (wr_ctr),
    .misfetch_d   (misfetch_d),
    .mispredict_d (mispredict_d)
  );

  // error pulses, registered
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      misfetch_q   <= 1'b0;
      mispredict_q <= 1'b0;
    end else begin
      misfetch_q   <= misfetch_d;
      mispredict_q <= mispredict_d;
    end
  end

  assign misfetch   = misfetch_q;
  assign mispredict = mispredict_q;

endmodule

// File: rtl/btb_redirect_chk.sv
module btb_redirect_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic            hit,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic            misfetch,
  input logic            mispredict
);

  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> hit);

  p_fallthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (next_pc == fetch_pc + PC_W'(4)));

  p_alloc_visible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |=> ((fetch_pc != $past(res_pc)) || hit));

  p_misfetch_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    misfetch |-> $past(res_valid && res_taken));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(misfetch && mispredict));

  p_pulse_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (misfetch || mispredict) |-> $past(res_valid));

endmodule

bind btb_redirect btb_redirect_chk #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .fetch_pc   (fetch_pc),
  .res_valid  (res_valid),
  .res_pc     (res_pc),
  .res_taken  (res_taken),
  .hit        (hit),
  .pred_taken (pred_taken),
  .next_pc    (next_pc),
  .misfetch   (misfetch),
  .mispredict (mispredict)
);

// File: tb/sim_btb_redirect.sv
`timescale 1ns/1ps
module sim_btb_redirect;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fetch_pc;
  logic        res_valid;
  logic [31:0] res_pc;
  logic        res_taken;
  logic [31:0] res_target;
  logic        hit, pred_taken, misfetch, mispredict;
  logic [31:0] next_pc;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model
  bit          m_v   [16];
  logic [27:0] m_tag [16];
  logic [31:0] m_tgt [16];
  logic [1:0]  m_ctr [16];
  bit exp_mf = 0, exp_mp = 0, prev_rv = 0;

  always #4 clk = ~clk;

  btb_redirect u0 (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target), .hit(hit), .pred_taken(pred_taken),
    .next_pc(next_pc), .misfetch(misfetch), .mispredict(mispredict)
  );

  function automatic logic [27:0] tag_of(input logic [31:0] pc);
    return {pc[31:6], pc[1:0]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 16; i++) m_v[i] = 0;
    exp_mf = 0; exp_mp = 0; prev_rv = 0;
  endtask

  // one cycle: check last cycle's pulses, drive, check lookup, advance model
  task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                      input bit rt, input logic [31:0] rtg, input string lbl);
    int fi, ri;
    bit h, p, rh;
    logic [31:0] np;
    @(negedge clk);
    chk({31'd0, misfetch},   {31'd0, exp_mf}, prev_rv ? "R8 misfetch"   : "R10 misfetch idle");
    chk({31'd0, mispredict}, {31'd0, exp_mp}, prev_rv ? "R9 mispredict" : "R10 mispredict idle");
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg;
    #1;
    fi = int'(fpc[5:2]);
    h  = m_v[fi] && (m_tag[fi] == tag_of(fpc));
    p  = h && m_ctr[fi][1];
    np = p ? m_tgt[fi] : fpc + 32'd4;
    chk({31'd0, hit},        {31'd0, h}, {lbl, " hit"});
    chk({31'd0, pred_taken}, {31'd0, p}, {lbl, " pred_taken"});
    chk(next_pc, np, {lbl, " next_pc"});
    exp_mf = 0; exp_mp = 0; prev_rv = rv;
    if (rv) begin
      ri = int'(rpc[5:2]);
      rh = m_v[ri] && (m_tag[ri] == tag_of(rpc));
      if (!rh) begin
        exp_mf = rt;
        if (rt) begin
          m_v[ri] = 1; m_tag[ri] = tag_of(rpc); m_tgt[ri] = rtg; m_ctr[ri] = 2'b10;
        end
      end else begin
        exp_mp = (m_ctr[ri][1] != rt) || (rt && m_ctr[ri][1] && m_tgt[ri] != rtg);
        if (rt && m_ctr[ri] != 2'b11) m_ctr[ri] = m_ctr[ri] + 2'd1;
        if (!rt && m_ctr[ri] != 2'b00) m_ctr[ri] = m_ctr[ri] - 2'd1;
        if (rt) m_tgt[ri] = rtg;
      end
    end
  endtask

  task automatic look(input logic [31:0] fpc, input string lbl);
    step(fpc, 0, 32'd0, 0, 32'd0, lbl);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; res_valid = 0;
    model_clear();
    #1;
    chk({31'd0, misfetch},   32'd0, "R1 misfetch in reset");
    chk({31'd0, mispredict}, 32'd0, "R1 mispredict in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  localparam logic [31:0] PA = 32'h0000_1048; // index 2
  localparam logic [31:0] PB = 32'h0000_2048; // same index, other tag
  localparam logic [31:0] T1 = 32'h0000_3000;
  localparam logic [31:0] T2 = 32'h0000_4000;

  initial begin
    void'($urandom(32'd2024));
    fetch_pc = 32'd0; res_valid = 0; res_pc = 0; res_taken = 0; res_target = 0;
    rst_n = 1'b1;
    do_reset();

    // R1: empty after reset
    look(PA, "R1");
    look(32'h0000_0000, "R1");
    // R5: not-taken miss allocates nothing
    step(PA, 1, PA, 0, T1, "R5");
    look(PA, "R5");
    // R4: taken miss allocates weakly taken
    step(PA, 1, PA, 1, T1, "R4");
    look(PA, "R4");
    look(PA | 32'h1, "R2 offset bits compared");
    // R6: saturate up, then train down
    step(PA, 1, PA, 1, T1, "R6");
    step(PA, 1, PA, 1, T1, "R6");
    look(PA, "R6 saturated taken");
    step(PA, 1, PA, 0, T1, "R6");
    step(PA, 1, PA, 0, T1, "R6");
    look(PA, "R6 weak not-taken");
    step(PA, 1, PA, 0, T1, "R6");
    step(PA, 1, PA, 0, T1, "R6");
    look(PA, "R6 saturated not-taken");
    // R7: taken with new target while predicted not-taken
    step(PA, 1, PA, 1, T2, "R7");
    step(PA, 1, PA, 1, T2, "R7");
    look(PA, "R7 new target");
    // R9: target-only mispredict
    step(PA, 1, PA, 1, T1, "R9");
    look(PA, "R9 target rewritten");
    // R7: not-taken hit keeps target
    step(PA, 1, PA, 0, T2, "R7");
    look(PA, "R7 target kept");
    // R4: alias evicts
    step(PB, 1, PB, 1, T2, "R4");
    look(PA, "R4 evicted");
    look(PB, "R4 alias present");
    // same-cycle lookup and resolve of one address
    step(PB, 1, PB, 1, T1, "R3");
    look(PB, "R3");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b, t;
      a = 32'h0000_1000 * (($urandom % 3) + 1) + 32'd4 * ($urandom % 4);
      b = 32'h0000_1000 * (($urandom % 3) + 1) + 32'd4 * ($urandom % 4);
      t = 32'h0008_0000 + 32'd16 * ($urandom % 3);
      step(a, ($urandom % 10) < 7, b, ($urandom % 10) < 6, t, "R2/R3 random");
    end
    look(32'h0, "R10 idle");

    // R1: reset in the middle of activity clears all entries
    do_reset();
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        look(32'h0000_1000 * (j + 1) + 32'd4 * i, "R1 after second reset");
    look(32'h0, "R1");

    done = 1;
    finish_run();
  end

endmodule